// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block receives a two-channel serial audio stream as a slave. A bit clock, a frame clock and a data line all come from outside. The block samples them in its own system clock domain after a synchronizer, finds the bit clock's rising edges, and rebuilds one left and one right sample per frame. Each sample comes out as a 24-bit two's-complement word. A word shorter than 24 bits sits in the upper bits, and the bits below it are zero.

Two configuration inputs select the framing and the word length. The framing is one-bit-delayed (I2S style), left-justified or right-justified. The word length is 16, 20 or 24 bits. The block measures every frame from one rising frame-clock edge to the next, and it accepts only 32, 48 or 64 bit-clock periods per frame. It releases both samples of a frame together, at the rising frame-clock edge that closes the frame. If the frame had any other length, it raises a one-cycle error pulse and emits nothing for that frame. A frame is the high half of the frame clock followed by the low half.

Top module: `aud_rx`

## Requirements
- R1: With `fmt` = 0 (one-bit-delayed), the half with the frame clock low is the left channel and the high half is the right channel. The MSB is carried by the second bit-clock rising edge of each half. The LSB of a word that fills its whole half lands on the first rising edge of the following half.
- R2: With `fmt` = 1 (left-justified), the MSB is carried by the first bit-clock rising edge of a half, and the frame-clock high half is the left channel.
- R3: With `fmt` = 2 (right-justified), the LSB is carried by the last bit-clock rising edge before the frame clock changes, and the frame-clock high half is the left channel.
- R4: Data bits are taken MSB first, at rising edges of the bit clock only.
- R5: `wlen` = 0, 1 and 2 select 16, 20 and 24 bits. The received word is placed from bit 23 downward and the bits below it are zero. Bit slots outside the word, whatever their level, do not change the output.
- R6: Frames of 32, 48 and 64 bit-clock rising edges between rising frame-clock edges are accepted.
- R7: A frame of any other length produces exactly one `ratio_err` pulse at its closing rising frame-clock edge. No sample strobe is produced for that frame.
- R8: After reset, the first rising frame-clock edge only starts framing. Samples appear only for complete frames after it.
- R9: `left_valid` and `right_valid` pulse together for one clock, in the clock after a bit-clock rising edge. `left_data` and `right_data` change only when a strobe is high.
- R10: During reset and after its release, until the first strobe, both data outputs are zero and `left_valid`, `right_valid` and `ratio_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_clk | input | 1 | External serial bit clock |
| frame_clk | input | 1 | External frame (channel select) clock |
| ser_data | input | 1 | Serial audio data |
| fmt | input | 2 | Framing: 0 one-bit-delayed, 1 left-justified, 2 right-justified, 3 as 0 |
| wlen | input | 2 | Word length: 0 = 16, 1 = 20, 2 or 3 = 24 bits |
| left_data | output | 24 | Last accepted left sample, left-aligned |
| left_valid | output | 1 | One-clock strobe for a new left sample |
| right_data | output | 24 | Last accepted right sample, left-aligned |
| right_valid | output | 1 | One-clock strobe for a new right sample |
| ratio_err | output | 1 | One-clock pulse on a frame with an unsupported length |

## Verification
The assertions assume the system clock oversamples the bit clock. Each high and low phase of the bit clock must span at least two clocks. The frame clock and the data line must change only while the bit clock is low, so that each synchronized rising edge sees settled data. The assertions also assume that `fmt` and `wlen` stay still while a frame is in flight. The bench drives all three serial lines from one task. That task holds every bit-clock phase for four system clocks and changes the frame clock and data only in the low phase. Between vectors it changes the configuration only while reset is held.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_DELAY1 = 2'd0,
    FMT_LEFT   = 2'd1,
    FMT_RIGHT  = 2'd2,
    FMT_SPARE  = 2'd3
  } fmt_e;

  function automatic int unsigned word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fclk_i,
  input  logic data_i,
  output logic bclk_rise,
  output logic fclk_s,
  output logic data_s
);
  logic [STAGES-1:0][2:0] pipe_q;
  logic                   bclk_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q   <= '0;
      bclk_d_q <= 1'b0;
    end else begin
      pipe_q[0] <= {bclk_i, fclk_i, data_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      bclk_d_q <= pipe_q[STAGES-1][2];
    end
  end

  assign bclk_rise = pipe_q[STAGES-1][2] & ~bclk_d_q;
  assign fclk_s    = pipe_q[STAGES-1][1];
  assign data_s    = pipe_q[STAGES-1][0];
endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame #(
  parameter int HALF_MAX = 32,
  localparam int CW = $clog2(2*HALF_MAX) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fclk,
  output logic          fclk_prev,
  output logic          fclk_edge,
  output logic          fclk_up,
  output logic [CW-1:0] half_len,
  output logic          frame_ok
);
  localparam logic [CW-1:0] LEN_A = CW'(HALF_MAX);
  localparam logic [CW-1:0] LEN_B = CW'(HALF_MAX * 3 / 2);
  localparam logic [CW-1:0] LEN_C = CW'(2 * HALF_MAX);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic          prev_q, prev_n;
  logic [CW-1:0] hcnt_q, hcnt_n, fcnt_q, fcnt_n;

  assign fclk_edge = rise & (fclk != prev_q);
  assign fclk_up   = rise & fclk & ~prev_q;

  always_comb begin
    prev_n = prev_q;
    hcnt_n = hcnt_q;
    fcnt_n = fcnt_q;
    if (rise) begin
      prev_n = fclk;
      if (fclk_edge)            hcnt_n = ONE;
      else if (hcnt_q != '1)    hcnt_n = hcnt_q + ONE;
      if (fclk_up)              fcnt_n = ONE;
      else if (fcnt_q != '1)    fcnt_n = fcnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hcnt_q <= '0;
      fcnt_q <= '0;
    end else begin
      prev_q <= prev_n;
      hcnt_q <= hcnt_n;
      fcnt_q <= fcnt_n;
    end
  end

  assign fclk_prev = prev_q;
  assign half_len  = hcnt_q;
  assign frame_ok  = (fcnt_q == LEN_A) || (fcnt_q == LEN_B) || (fcnt_q == LEN_C);
endmodule

// File: rtl/aud_rx_extract.sv
module aud_rx_extract
  import aud_rx_pkg::*;
#(
  parameter int DW = 24,
  parameter int SW = 32,
  parameter int CW = 7
) (
  input  logic [SW-1:0] hist,
  input  logic          bit_now,
  input  logic [CW-1:0] half_len,
  input  logic [1:0]    fmt,
  input  logic [1:0]    wlen,
  output logic [DW-1:0] word
);
  fmt_e          mode;
  int unsigned   nbits;
  logic [CW-1:0] len;
  logic [SW-1:0] src, aligned;
  logic [DW-1:0] rj, mask;

  always_comb begin
    mode    = fmt_e'(fmt);
    nbits   = word_bits(wlen);
    len     = (half_len > CW'(SW)) ? CW'(SW) : half_len;
    src     = (mode == FMT_LEFT) ? hist : {hist[SW-2:0], bit_now};
    aligned = src << (CW'(SW) - len);
    rj      = hist[DW-1:0] << (DW - int'(nbits));
    mask    = {DW{1'b1}} << (DW - int'(nbits));
    word    = ((mode == FMT_RIGHT) ? rj : aligned[SW-1 -: DW]) & mask;
  end
endmodule

// File: rtl/aud_rx.sv
module aud_rx
  import aud_rx_pkg::*;
#(
  parameter int DW          = 24,
  parameter int HALF_MAX    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_clk,
  input  logic          frame_clk,
  input  logic          ser_data,
  input  logic [1:0]    fmt,
  input  logic [1:0]    wlen,
  output logic [DW-1:0] left_data,
  output logic          left_valid,
  output logic [DW-1:0] right_data,
  output logic          right_valid,
  output logic          ratio_err
);
  localparam int SW = HALF_MAX;
  localparam int CW = $clog2(2*HALF_MAX) + 1;

  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  logic          bclk_rise, fclk_s, data_s;
  logic          fclk_prev, fclk_edge, fclk_up, frame_ok;
  logic [CW-1:0] half_len;
  logic [DW-1:0] word;
  logic          low_is_left;

  logic [SW-1:0] hist_q, hist_n;
  logic [DW-1:0] held_q, held_n, ldat_q, ldat_n, rdat_q, rdat_n;
  logic          held_ok_q, held_ok_n, armed_q, armed_n;
  logic          lval_q, lval_n, rval_q, rval_n, err_q, err_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .bclk_i(bit_clk), .fclk_i(frame_clk), .data_i(ser_data),
    .bclk_rise(bclk_rise), .fclk_s(fclk_s), .data_s(data_s)
  );

  aud_rx_frame #(.HALF_MAX(HALF_MAX)) u_frame (
    .clk(clk), .rst_n(rst_int_n), .rise(bclk_rise), .fclk(fclk_s),
    .fclk_prev(fclk_prev), .fclk_edge(fclk_edge), .fclk_up(fclk_up),
    .half_len(half_len), .frame_ok(frame_ok)
  );

  aud_rx_extract #(.DW(DW), .SW(SW), .CW(CW)) u_extract (
    .hist(hist_q), .bit_now(data_s), .half_len(half_len),
    .fmt(fmt), .wlen(wlen), .word(word)
  );

  assign low_is_left = (fmt_e'(fmt) == FMT_DELAY1) || (fmt_e'(fmt) == FMT_SPARE);

  always_comb begin
    hist_n    = hist_q;
    held_n    = held_q;
    held_ok_n = held_ok_q;
    armed_n   = armed_q;
    ldat_n    = ldat_q;
    rdat_n    = rdat_q;
    lval_n    = 1'b0;
    rval_n    = 1'b0;
    err_n     = 1'b0;
    if (bclk_rise) begin
      hist_n = {hist_q[SW-2:0], data_s};
      if (fclk_edge && fclk_prev) begin
        held_n    = word;
        held_ok_n = armed_q;
      end
      if (fclk_up) begin
        armed_n   = 1'b1;
        held_ok_n = 1'b0;
        if (armed_q) begin
          if (frame_ok && held_ok_q) begin
            lval_n = 1'b1;
            rval_n = 1'b1;
            ldat_n = low_is_left ? word : held_q;
            rdat_n = low_is_left ? held_q : word;
          end else begin
            err_n = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hist_q    <= '0;
      held_q    <= '0;
      held_ok_q <= 1'b0;
      armed_q   <= 1'b0;
      ldat_q    <= '0;
      rdat_q    <= '0;
      lval_q    <= 1'b0;
      rval_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      hist_q    <= hist_n;
      held_q    <= held_n;
      held_ok_q <= held_ok_n;
      armed_q   <= armed_n;
      ldat_q    <= ldat_n;
      rdat_q    <= rdat_n;
      lval_q    <= lval_n;
      rval_q    <= rval_n;
      err_q     <= err_n;
    end
  end

  assign left_data   = ldat_q;
  assign right_data  = rdat_q;
  assign left_valid  = lval_q;
  assign right_valid = rval_q;
  assign ratio_err   = err_q;
endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bclk_rise,
  input logic [DW-1:0] left_data,
  input logic          left_valid,
  input logic [DW-1:0] right_data,
  input logic          right_valid,
  input logic          ratio_err
);
  assert_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid == right_valid);

  assert_strobe_after_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |-> $past(bclk_rise));

  assert_left_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !left_valid |-> $stable(left_data));

  assert_right_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !right_valid |-> $stable(right_data));

  assert_err_no_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |-> !left_valid && !right_valid);

  assert_err_after_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |-> $past(bclk_rise));

  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |=> !ratio_err);
endmodule

bind aud_rx aud_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise),
  .left_data(left_data), .left_valid(left_valid),
  .right_data(right_data), .right_valid(right_valid),
  .ratio_err(ratio_err)
);

// File: tb/sim_aud_rx.sv
module sim_aud_rx;
  logic        clk = 1'b0;
  logic        rst_n, bit_clk, frame_clk, ser_data;
  logic [1:0]  fmt, wlen;
  logic [23:0] left_data, right_data;
  logic        left_valid, right_valid, ratio_err;

  int nchk = 0, nerr = 0;
  int nv, ne;
  logic [23:0] last_l, last_r;
  logic mon_clr = 1'b0;
  logic carry;

  always #10 clk = ~clk;

  aud_rx u0 (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_clk(frame_clk),
    .ser_data(ser_data), .fmt(fmt), .wlen(wlen),
    .left_data(left_data), .left_valid(left_valid),
    .right_data(right_data), .right_valid(right_valid), .ratio_err(ratio_err)
  );

  // fmt, wlen, half length, left word, right word
  // R1, R2, R3 by fmt; R4, R5 through every entry; R6 through half lengths 16/24/32
  localparam logic [57:0] VTAB [9] = '{
    {2'd0, 2'd2, 6'd32, 24'hA5C3E1, 24'h1E2D3C},
    {2'd0, 2'd0, 6'd16, 24'h8001FF, 24'h7FFE00},
    {2'd0, 2'd1, 6'd24, 24'h123456, 24'hFEDCBA},
    {2'd1, 2'd2, 6'd32, 24'h800001, 24'h7FFFFE},
    {2'd1, 2'd0, 6'd24, 24'hC0FFEE, 24'h0BADF0},
    {2'd2, 2'd2, 6'd32, 24'h13579B, 24'h2468AC},
    {2'd2, 2'd1, 6'd24, 24'hABCDEF, 24'h654321},
    {2'd2, 2'd0, 6'd16, 24'h55AA55, 24'hAA55AA},
    {2'd1, 2'd1, 6'd32, 24'h0F0F0F, 24'hF0F0F0}
  };

  always @(negedge clk) begin
    if (mon_clr) begin
      nv = 0; ne = 0; last_l = '0; last_r = '0;
    end else begin
      if (left_valid) begin nv++; last_l = left_data; last_r = right_data; end
      if (ratio_err) ne++;
    end
  end

  function automatic int bits_of(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
  endfunction

  function automatic logic [23:0] mask_of(input logic [1:0] c);
    return (c == 2'd0) ? 24'hFFFF00 : (c == 2'd1) ? 24'hFFFFF0 : 24'hFFFFFF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic fl, input logic d);
    @(negedge clk);
    frame_clk = fl; ser_data = d; bit_clk = 1'b0;
    repeat (4) @(negedge clk);
    bit_clk = 1'b1;
    repeat (4) @(negedge clk);
    bit_clk = 1'b0;
  endtask

  task automatic send_half(input logic fl, input logic [1:0] f, input int wl,
                           input int hl, input logic [23:0] w);
    for (int k = 0; k < hl; k++) begin
      logic b;
      b = 1'b1;
      if (f == 2'd1) begin
        if (k < wl) b = w[23-k];
      end else if (f == 2'd2) begin
        if (k >= hl - wl) b = w[23-(k-(hl-wl))];
      end else begin
        if (k == 0) b = carry;
        else if (k <= wl) b = w[23-(k-1)];
      end
      tick(fl, b);
    end
    carry = (wl == hl) ? w[24-hl] : 1'b1;
  endtask

  task automatic send_frame(input logic [1:0] f, input logic [1:0] wc, input int hl,
                            input logic [23:0] lw, input logic [23:0] rw);
    logic low_left;
    low_left = (f == 2'd0);
    send_half(1'b1, f, bits_of(wc), hl, low_left ? rw : lw);
    send_half(1'b0, f, bits_of(wc), hl, low_left ? lw : rw);
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] wc);
    rst_n = 1'b0; bit_clk = 1'b0; frame_clk = 1'b0; ser_data = 1'b0;
    fmt = f; wlen = wc; carry = 1'b1;
    mon_clr = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R10: reset state
    do_reset(2'd0, 2'd2);
    check("R10 left_data", {8'h0, left_data}, 32'h0);
    check("R10 right_data", {8'h0, right_data}, 32'h0);
    check("R10 strobes", {29'h0, left_valid, right_valid, ratio_err}, 32'h0);

    // table walk: two frames plus one closing edge each
    for (int i = 0; i < 9; i++) begin
      logic [1:0] f, wc;
      int hl;
      logic [23:0] lw, rw;
      string tag;
      f  = VTAB[i][57:56];
      wc = VTAB[i][55:54];
      hl = int'(VTAB[i][53:48]);
      lw = VTAB[i][47:24];
      rw = VTAB[i][23:0];
      tag = (f == 2'd0) ? "R1" : (f == 2'd1) ? "R2" : "R3";
      do_reset(f, wc);
      send_frame(f, wc, hl, lw, rw);
      send_frame(f, wc, hl, lw, rw);
      tick(1'b1, 1'b1);
      repeat (12) @(negedge clk);
      check($sformatf("%s R6 R9 vec%0d count", tag, i), nv, 2);
      check($sformatf("%s R4 R5 vec%0d left", tag, i), {8'h0, last_l}, {8'h0, lw & mask_of(wc)});
      check($sformatf("%s R4 R5 vec%0d right", tag, i), {8'h0, last_r}, {8'h0, rw & mask_of(wc)});
      check($sformatf("%s R7 vec%0d no error", tag, i), ne, 0);
    end

    // R7: 40-edge frame rejected, following good frame accepted
    do_reset(2'd1, 2'd2);
    send_frame(2'd1, 2'd2, 20, 24'h111111, 24'h222222);
    send_frame(2'd1, 2'd2, 32, 24'h345678, 24'h9ABCDE);
    tick(1'b1, 1'b1);
    repeat (12) @(negedge clk);
    check("R7 error pulses", ne, 1);
    check("R7 samples emitted", nv, 1);
    check("R7 recovered left", {8'h0, last_l}, 32'h00345678);
    check("R7 recovered right", {8'h0, last_r}, 32'h009ABCDE);

    // R8: leading partial half before first rising edge yields no sample
    do_reset(2'd1, 2'd2);
    send_half(1'b0, 2'd1, 24, 16, 24'hFFFFFF);
    send_frame(2'd1, 2'd2, 32, 24'h0C0C0C, 24'h303030);
    check("R8 nothing before complete frame", nv, 0);
    tick(1'b1, 1'b1);
    repeat (12) @(negedge clk);
    check("R8 one sample pair", nv, 1);
    check("R8 no error", ne, 0);
    check("R8 left", {8'h0, last_l}, 32'h000C0C0C);

    finish_run();
  end
endmodule